// File: doc/BRIEF.md
# Signed Phase Error Coder

This block turns one raw phase comparison into a number a digital loop filter can use. One input bit gives the polarity of the comparison: it tells which of two clock edges came first. A 14-stage thermometer vector from a delay line gives the size of the error. When a capture strobe is high, the block counts the fired stages, adds one and applies the polarity. It stores the result as a 5-bit two's-complement word and raises a valid flag for one cycle.

Zero is never produced. An error smaller than one delay stage still gives a magnitude of one, with the polarity taken from the sign input. The loop therefore always gets a correctly signed, nonzero command. The stored word stays unchanged between strobes, so the filter can sample it whenever it needs to.

Top module: `phase_err_coder`

## Requirements
- R1: While reset is asserted, and after it until the first strobed capture, the output word is +1 (5'b00001) and valid is low.
- R2: A strobed capture sets the output magnitude to the number of ones in the thermometer vector plus one. Clean codes with 0 to 14 fired stages therefore map to magnitudes 1 to 15.
- R3: A sign input of 1 gives a positive output. A sign input of 0 gives the two's-complement negation of the magnitude, so bit 4 of the output is the inverse of the captured sign.
- R4: The output word is never zero. Its value always lies in -15..-1 or +1..+15.
- R5: An all-zero thermometer vector gives +1 with sign 1 and -1 (5'b11111) with sign 0.
- R6: The magnitude depends only on how many bits are set, not on where they are. A single bubble in the thermometer vector therefore moves the result by at most one step.
- R7: The capture is taken at the rising clock edge where the strobe is high. The new word and a high valid appear after that same edge. Valid is high only in the cycle after a strobed edge, and it stays high through consecutive strobes.
- R8: On an edge where the strobe is low, changes on the sign and thermometer inputs have no effect: the output word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cap_i | input | 1 | Capture strobe, asserted when the later of the two compared edges has arrived |
| lag_i | input | 1 | Sign of the phase error: 1 means the local oscillator lags |
| therm_i | input | 14 | Thermometer code from the delay line; bit k is set when stage k has fired |
| err_o | output | 5 | Registered two's-complement phase error |
| vld_o | output | 1 | One-cycle flag marking a newly captured word |

## Verification
The bench applies every clean thermometer level under both signs. This separates off-by-one errors in the magnitude from errors in the negation, and the all-zero level proves that the output has no zero code. Bubbled and scattered patterns with the same number of ones show that bit position does not matter. Runs with the strobe low while the inputs change show that the output holds, and back-to-back strobes pin down when valid rises and falls. A long pseudo-random run then compares every cycle against a behavioural model that works with plain integers.

// File: rtl/phe_pkg.sv
package phe_pkg;
  // Number of delay stages in the thermometer code
  parameter int unsigned THERM_W_DEF = 14;

  // Bits needed to hold a count of 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // Signed width that holds +/-(n+1)
  function automatic int unsigned word_bits(input int unsigned n);
    return $clog2(n + 2) + 1;
  endfunction
endpackage

// File: rtl/therm_popcount.sv
module therm_popcount #(
  parameter int unsigned W     = 14,
  parameter int unsigned CNT_W = 4
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] psum [0:W];

  assign psum[0] = '0;

  // Ripple of ones counters; bubbles only add or remove single ones
  for (genvar k = 0; k < W; k++) begin : g_acc
    assign psum[k+1] = psum[k] + CNT_W'(vec_i[k]);
  end

  assign cnt_o = psum[W];

  always_comb begin
    assert (cnt_o <= CNT_W'(W)) else $error("p_cnt_bound_r2: count above stage total");
  end
endmodule

// File: rtl/err_sign_apply.sv
module err_sign_apply #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned OUT_W = 5
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lag_i,
  output logic [OUT_W-1:0] word_o
);
  logic [OUT_W-1:0] mag;

  // Offset by one: a sub-resolution error is still a unit command
  assign mag    = OUT_W'(cnt_i) + OUT_W'(1);
  assign word_o = lag_i ? mag : (~mag + OUT_W'(1));

  always_comb begin
    assert (mag != '0) else $error("p_mag_nonzero_r4: zero magnitude");
  end
endmodule

// File: rtl/phase_err_coder.sv
module phase_err_coder #(
  parameter int unsigned THERM_W = phe_pkg::THERM_W_DEF
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cap_i,
  input  logic                                      lag_i,
  input  logic [THERM_W-1:0]                        therm_i,
  output logic [phe_pkg::word_bits(THERM_W)-1:0]    err_o,
  output logic                                      vld_o
);
  localparam int unsigned CNT_W = phe_pkg::cnt_bits(THERM_W);
  localparam int unsigned OUT_W = phe_pkg::word_bits(THERM_W);

  // Reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CNT_W-1:0] fired_cnt;
  logic [OUT_W-1:0] coded;

  therm_popcount #(.W(THERM_W), .CNT_W(CNT_W)) u_cnt (
    .vec_i (therm_i),
    .cnt_o (fired_cnt)
  );

  err_sign_apply #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_sgn (
    .cnt_i  (fired_cnt),
    .lag_i  (lag_i),
    .word_o (coded)
  );

  // Next state
  logic [OUT_W-1:0] err_d, err_q;
  logic             vld_d, vld_q;

  always_comb begin
    err_d = err_q;
    vld_d = 1'b0;
    if (cap_i) begin
      err_d = coded;
      vld_d = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= OUT_W'(1);
      vld_q <= 1'b0;
    end else begin
      err_q <= err_d;
      vld_q <= vld_d;
    end
  end

  assign err_o = err_q;
  assign vld_o = vld_q;

  p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q != '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_i |=> $stable(err_q));

  p_vld_src_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_i |=> vld_q);

  p_vld_drop_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_i |=> !vld_q);

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_i |=> (err_q[OUT_W-1] == !$past(lag_i)));
endmodule

// File: tb/phase_err_coder_bench.sv
module phase_err_coder_bench;
  localparam int TW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cap_i;
  logic          lag_i;
  logic [TW-1:0] therm_i;
  logic [4:0]    err_o;
  logic          vld_o;

  int checks = 0;
  int errors = 0;
  int exp_err;
  int exp_vld;
  bit done = 0;

  always #10 clk = ~clk;

  phase_err_coder u_phase_err_coder (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .lag_i(lag_i),
    .therm_i(therm_i), .err_o(err_o), .vld_o(vld_o)
  );

  function automatic int ones(input logic [TW-1:0] v);
    int n = 0;
    for (int k = 0; k < TW; k++) if (v[k]) n++;
    return n;
  endfunction

  task automatic compare(input string tag);
    int act = int'($signed(err_o));
    checks++;
    if (act != exp_err || int'(vld_o) != exp_vld) begin
      errors++;
      $display("FAIL %s: err=%0d vld=%0d expected err=%0d vld=%0d",
               tag, act, vld_o, exp_err, exp_vld);
    end
    if (act == 0 || act > 15 || act < -15) begin
      errors++;
      $display("FAIL R4: err=%0d expected nonzero within +/-15", act);
    end
  endtask

  // Drive at negedge, let the edge pass, model it, check mid-cycle
  task automatic step(input bit cap, input bit lag, input logic [TW-1:0] th, input string tag);
    @(negedge clk);
    cap_i = cap; lag_i = lag; therm_i = th;
    @(posedge clk);
    if (cap) begin
      exp_err = lag ? ones(th) + 1 : -(ones(th) + 1);
      exp_vld = 1;
    end else begin
      exp_vld = 0;
    end
    #5;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cap_i = 1'b1; lag_i = 1'b0; therm_i = '1;
    exp_err = 1; exp_vld = 0;
    repeat (2) @(posedge clk);
    #5; compare("R1");
    @(negedge clk); rst_n = 1'b1; cap_i = 1'b0;
    repeat (3) begin
      @(posedge clk); #5; compare("R1");
    end
  endtask

  initial begin
    rst_n = 1'b0; cap_i = 1'b0; lag_i = 1'b0; therm_i = '0;
    do_reset();

    // R2 R3 R5: every clean level, both polarities
    for (int n = 0; n <= TW; n++) begin
      logic [TW-1:0] th = (TW'(1) << n) - TW'(1);
      if (n == TW) th = '1;
      step(1, 1, th, n == 0 ? "R5" : "R2");
      step(1, 0, th, n == 0 ? "R5" : "R3");
    end

    // R6: bubbles and scattered ones
    step(1, 1, 14'b00000001110111, "R6");
    step(1, 0, 14'b00011111101111, "R6");
    step(1, 1, 14'b10000000000000, "R6");
    step(1, 0, 14'b01010101010101, "R6");
    step(1, 1, 14'b11111111111110, "R6");

    // R8: inputs wander with strobe low
    step(1, 0, 14'b00000000111111, "R7");
    step(0, 1, 14'b11111111111111, "R8");
    step(0, 0, 14'b00000000000000, "R8");
    step(0, 1, 14'b10101010101010, "R8");

    // R7: back-to-back strobes then gap
    step(1, 1, 14'b00000000000011, "R7");
    step(1, 1, 14'b00000000000111, "R7");
    step(1, 0, 14'b00000000001111, "R7");
    step(0, 0, 14'b00000000000000, "R7");
    step(1, 1, 14'b00000000000000, "R7");

    // R1 again mid-run
    do_reset();

    // Pseudo-random mix, compared every clock
    for (int i = 0; i < 400; i++) begin
      bit c = $urandom_range(0, 2) != 0;
      step(c, 1'($urandom_range(0, 1)), TW'($urandom), "R4");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule